// File: doc/BRIEF.md
# Pipelined Binary Trie Prefix Lookup

This block looks up the longest matching prefix for a 32-bit destination address. It walks a binary trie in which every prefix has been pushed down to the leaves. Each trie level is its own pipeline stage with a private node memory, and each stage inspects exactly one address bit, starting from the most significant bit. One new lookup can enter on every clock. Each lookup leaves after a fixed number of cycles, carrying a next-hop index or a miss flag. Results come out in the order the lookups went in.

Software fills the node memories through a write port that addresses any stage and any word. Writes go on alongside a running lookup stream and never hold it up. A node word is either a leaf, which carries a next-hop index, or an inner node, which carries the index of a sibling pair in the next stage. The address bit consumed at that stage picks the left or the right word of the pair.

Top module: `trie_lpm_pipe`

## Requirements
- R1: Stage k (k = 0 at the input) branches on address bit ADDR_W-1-k. A 0 bit reads the even (left) word 2p of sibling pair p, and a 1 bit reads the odd (right) word 2p+1.
- R2: A node word is {leaf flag, payload}, with the flag in the top bit. For an inner node (flag 0), the low PTR_W payload bits are the index of a sibling pair in the next stage. Stage 0 always starts at pair 0. Pair indices up to 2**PTR_W-1 are usable.
- R3: When the walk reads a leaf word (flag 1), the lookup resolves as a hit, with out_miss = 0 and out_nh equal to the low NH_W payload bits.
- R4: Every lookup appears on out_valid exactly ADDR_W cycles after it was accepted. A lookup resolved in an early stage passes through the later stages unchanged.
- R5: An inner word whose pair index is zero (null) resolves the lookup as a miss with out_nh = 0. So does an inner word read in the last stage.
- R6: A lookup is accepted on every cycle in which in_valid is high, and results leave in acceptance order with one result per accepted lookup.
- R7: A write (wr_en with wr_stage, wr_index, wr_leaf, wr_payload) is seen by reads from the cycle after it. A read of the same word in the write's own cycle returns the old contents. Lookups are never stalled by writes.
- R8: While reset is asserted, and after it is released, out_valid is 0 until a new lookup has travelled the pipeline. Lookups in flight at reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A lookup is presented this cycle |
| in_addr | input | ADDR_W | Destination address to look up |
| wr_en | input | 1 | Write one node word this cycle |
| wr_stage | input | $clog2(ADDR_W) | Stage whose memory is written |
| wr_index | input | PTR_W+1 | Word index within that stage (pair index and side bit) |
| wr_leaf | input | 1 | Leaf flag of the written word |
| wr_payload | input | max(PTR_W,NH_W) | Next-hop index or child pair index |
| out_valid | output | 1 | A result is present |
| out_nh | output | NH_W | Next-hop index of the result, zero on a miss |
| out_miss | output | 1 | No prefix matched the address |

## Verification
A corrupted pair pointer or a wrong bit select sends a walk to the wrong sibling. This shows at the ports as a wrong next-hop index, or as a false miss, on the result that leaves ADDR_W cycles after the lookup entered. A token that fails to carry its resolved result unchanged would show the same way, as would a broken pipeline valid chain, which also shows as a missing or shifted result in the back-to-back stream. The order and latency of every result are compared against the acceptance cycle. A write that lands in the wrong cycle is exposed by a lookup that reads the same word in the write's own cycle and one that reads it in the cycle after.

// File: rtl/trie_pkg.sv
package trie_pkg;

  typedef enum logic [1:0] {
    WALK_ACTIVE = 2'd0,
    WALK_HIT    = 2'd1,
    WALK_MISS   = 2'd2
  } walk_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
  parameter int WORD_W = 9,
  parameter int IDX_W  = 4,
  localparam int DEPTH = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  // write port: takes effect at the clock edge, so a read in the same
  // cycle still sees the previous word
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  // lookup read port
  assign rdata = mem_q[raddr];

  // R7: a word written in one cycle is returned to a read of it in the next
  p_wr_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && (raddr == $past(waddr))) |-> (rdata == $past(wdata)));

endmodule

// File: rtl/trie_stage.sv
module trie_stage
  import trie_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 3,
  parameter int NH_W     = 8,
  parameter int STAGE_ID = 0,
  localparam int IDX_W   = PTR_W + 1,
  localparam int PAY_W   = max_int(PTR_W, NH_W),
  localparam int WORD_W  = PAY_W + 1,
  localparam int BIT_POS = ADDR_W - 1 - STAGE_ID,
  localparam bit IS_LAST = (STAGE_ID == ADDR_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  walk_state_e       in_state,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic [NH_W-1:0]   in_nh,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_leaf,
  input  logic [PAY_W-1:0]  wr_payload,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output walk_state_e       out_state,
  output logic [PTR_W-1:0]  out_ptr,
  output logic [NH_W-1:0]   out_nh
);

  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              rd_leaf;
  logic [PAY_W-1:0]  rd_pay;
  logic [PTR_W-1:0]  rd_child;

  walk_state_e       nxt_state;
  logic [PTR_W-1:0]  nxt_ptr;
  logic [NH_W-1:0]   nxt_nh;

  // sibling pair chosen by the incoming pointer, side by this stage's bit
  assign rd_idx = {in_ptr, in_addr[BIT_POS]};

  trie_node_mem #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) node_mem_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_index),
    .wdata ({wr_leaf, wr_payload}),
    .raddr (rd_idx),
    .rdata (rd_word)
  );

  assign rd_leaf  = rd_word[PAY_W];
  assign rd_pay   = rd_word[PAY_W-1:0];
  assign rd_child = rd_pay[PTR_W-1:0];

  // next-state: resolve on a leaf, a null pointer or the last level
  always_comb begin
    nxt_state = in_state;
    nxt_ptr   = in_ptr;
    nxt_nh    = in_nh;
    if (in_state == WALK_ACTIVE) begin
      if (rd_leaf) begin
        nxt_state = WALK_HIT;
        nxt_nh    = rd_pay[NH_W-1:0];
      end else if ((rd_child == '0) || IS_LAST) begin
        nxt_state = WALK_MISS;
        nxt_nh    = '0;
      end else begin
        nxt_ptr   = rd_child;
      end
    end
  end

  // register: valid is reset, the token is loaded only under its enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr  <= in_addr;
      out_state <= nxt_state;
      out_ptr   <= nxt_ptr;
      out_nh    <= nxt_nh;
    end
  end

  // R4: a token resolved upstream passes this stage untouched
  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_state != WALK_ACTIVE)) |=>
      ((out_state == $past(in_state)) && (out_nh == $past(in_nh))));

  // R3: a leaf read turns an active walk into a hit with the leaf payload
  p_leaf_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_state == WALK_ACTIVE) && rd_leaf) |=>
      ((out_state == WALK_HIT) && (out_nh == $past(rd_pay[NH_W-1:0]))));

  // R5: an inner word with a null pair index ends the walk as a miss
  p_null_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_state == WALK_ACTIVE) && !rd_leaf && (rd_child == '0)) |=>
      ((out_state == WALK_MISS) && (out_nh == '0)));

endmodule

// File: rtl/trie_rst_sync.sv
module trie_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/trie_lpm_pipe.sv
module trie_lpm_pipe
  import trie_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PTR_W   = 3,
  parameter int NH_W    = 8,
  localparam int IDX_W  = PTR_W + 1,
  localparam int PAY_W  = max_int(PTR_W, NH_W),
  localparam int SEL_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_stage,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_leaf,
  input  logic [PAY_W-1:0]  wr_payload,
  output logic              out_valid,
  output logic [NH_W-1:0]   out_nh,
  output logic              out_miss
);

  localparam int STAGES = ADDR_W;

  logic              rst_n_sync;
  logic              stg_valid [STAGES+1];
  logic [ADDR_W-1:0] stg_addr  [STAGES+1];
  walk_state_e       stg_state [STAGES+1];
  logic [PTR_W-1:0]  stg_ptr   [STAGES+1];
  logic [NH_W-1:0]   stg_nh    [STAGES+1];
  logic              unused_tail;

  trie_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // every lookup enters at the root pair with an active walk
  assign stg_valid[0] = in_valid;
  assign stg_addr[0]  = in_addr;
  assign stg_state[0] = WALK_ACTIVE;
  assign stg_ptr[0]   = '0;
  assign stg_nh[0]    = '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_level
    logic lvl_wr;
    assign lvl_wr = wr_en && (wr_stage == SEL_W'(k));

    trie_stage #(
      .ADDR_W   (ADDR_W),
      .PTR_W    (PTR_W),
      .NH_W     (NH_W),
      .STAGE_ID (k)
    ) stage_i (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .in_valid   (stg_valid[k]),
      .in_addr    (stg_addr[k]),
      .in_state   (stg_state[k]),
      .in_ptr     (stg_ptr[k]),
      .in_nh      (stg_nh[k]),
      .wr_en      (lvl_wr),
      .wr_index   (wr_index),
      .wr_leaf    (wr_leaf),
      .wr_payload (wr_payload),
      .out_valid  (stg_valid[k+1]),
      .out_addr   (stg_addr[k+1]),
      .out_state  (stg_state[k+1]),
      .out_ptr    (stg_ptr[k+1]),
      .out_nh     (stg_nh[k+1])
    );
  end

  assign out_valid   = stg_valid[STAGES];
  assign out_nh      = stg_nh[STAGES];
  assign out_miss    = (stg_state[STAGES] == WALK_MISS);
  assign unused_tail = ^{stg_addr[STAGES], stg_ptr[STAGES]};

  // R4: nothing leaves the last stage still walking
  p_resolved_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid |-> (stg_state[STAGES] != WALK_ACTIVE));

  // R5: a miss always reports next-hop index zero
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_valid && out_miss) |-> (out_nh == '0));

endmodule

// File: tb/trie_lpm_pipe_tb_top.sv
module trie_lpm_pipe_tb_top;

  localparam int ADDR_W = 32;
  localparam int PTR_W  = 3;
  localparam int NH_W   = 8;
  localparam int IDX_W  = PTR_W + 1;
  localparam int PAY_W  = 8;
  localparam int SEL_W  = 5;
  localparam int WD_LIMIT = 20000;

  // {address, expected miss, expected next hop}
  localparam logic [40:0] VECS [12] = '{
    {32'h0000_0000, 1'b0, 8'd2},
    {32'h2000_0000, 1'b0, 8'd1},
    {32'h4000_0000, 1'b0, 8'd3},
    {32'h4800_0000, 1'b0, 8'd4},
    {32'h5000_0000, 1'b0, 8'd3},
    {32'h5800_0000, 1'b0, 8'd5},
    {32'h6000_0000, 1'b0, 8'd6},
    {32'h8000_0000, 1'b1, 8'd0},
    {32'hC000_0000, 1'b0, 8'd7},
    {32'hE000_0000, 1'b0, 8'd8},
    {32'hFFFF_FFFF, 1'b0, 8'd8},
    {32'h4FFF_FFFF, 1'b0, 8'd4}
  };

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [ADDR_W-1:0] in_addr;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_stage;
  logic [IDX_W-1:0]  wr_index;
  logic              wr_leaf;
  logic [PAY_W-1:0]  wr_payload;
  logic              out_valid;
  logic [NH_W-1:0]   out_nh;
  logic              out_miss;

  int n_chk;
  int n_fail;
  int cyc;
  int wr_q;
  int rd_q;
  bit flushing;
  bit flush_seen;
  bit done;

  logic [NH_W-1:0] exp_nh   [256];
  logic            exp_miss [256];
  int              exp_cyc  [256];
  string           exp_tag  [256];

  trie_lpm_pipe #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .NH_W   (NH_W)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .wr_en      (wr_en),
    .wr_stage   (wr_stage),
    .wr_index   (wr_index),
    .wr_leaf    (wr_leaf),
    .wr_payload (wr_payload),
    .out_valid  (out_valid),
    .out_nh     (out_nh),
    .out_miss   (out_miss)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  // result monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (flushing) begin
        flush_seen = 1'b1;
      end else if (rd_q == wr_q) begin
        chk("R6 unexpected result", 32'd1, 32'd0);
      end else begin
        chk({exp_tag[rd_q], " next hop"}, 32'(out_nh), 32'(exp_nh[rd_q]));
        chk({exp_tag[rd_q], " miss"}, 32'(out_miss), 32'(exp_miss[rd_q]));
        chk("R4 latency", 32'(cyc - exp_cyc[rd_q]), 32'(ADDR_W));
        rd_q++;
      end
    end
  end

  task automatic node_wr(input int stg, input int idx, input logic leaf, input int pay);
    @(negedge clk);
    wr_en      = 1'b1;
    wr_stage   = SEL_W'(stg);
    wr_index   = IDX_W'(idx);
    wr_leaf    = leaf;
    wr_payload = PAY_W'(pay);
    @(negedge clk);
    wr_en      = 1'b0;
  endtask

  // drive at the current negedge; caller handles timing
  task automatic push(input logic [31:0] a, input logic miss, input logic [7:0] nh, input string tag);
    in_valid       = 1'b1;
    in_addr        = a;
    exp_nh[wr_q]   = nh;
    exp_miss[wr_q] = miss;
    exp_cyc[wr_q]  = cyc;
    exp_tag[wr_q]  = tag;
    wr_q++;
  endtask

  task automatic drain();
    while (rd_q != wr_q) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; wr_q = 0; rd_q = 0;
    flushing = 1'b0; flush_seen = 1'b0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    wr_en = 1'b0; wr_stage = '0; wr_index = '0; wr_leaf = 1'b0; wr_payload = '0;
    repeat (4) @(negedge clk);
    chk("R8 valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 valid after reset", 32'(out_valid), 32'd0);

    // R2: table for prefixes 0*,000*,010*,01001*,01011*,011*,110*,111*
    node_wr(0, 0, 1'b0, 1);   // "0"  -> pair 1
    node_wr(0, 1, 1'b0, 2);   // "1"  -> pair 2
    node_wr(1, 2, 1'b0, 1);   // "00" -> pair 1
    node_wr(1, 3, 1'b0, 2);   // "01" -> pair 2
    node_wr(1, 4, 1'b0, 0);   // "10" null
    node_wr(1, 5, 1'b0, 3);   // "11" -> pair 3
    node_wr(2, 2, 1'b1, 2);
    node_wr(2, 3, 1'b1, 1);
    node_wr(2, 4, 1'b0, 1);
    node_wr(2, 5, 1'b1, 6);
    node_wr(2, 6, 1'b1, 7);
    node_wr(2, 7, 1'b1, 8);
    node_wr(3, 2, 1'b0, 1);
    node_wr(3, 3, 1'b0, 2);
    node_wr(4, 2, 1'b1, 3);
    node_wr(4, 3, 1'b1, 4);
    node_wr(4, 4, 1'b1, 3);
    node_wr(4, 5, 1'b1, 5);

    // R1 R3 R5 R6: table walked back to back
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      push(VECS[i][40:9], VECS[i][8], VECS[i][7:0], VECS[i][8] ? "R5 null" : "R1 R3 walk");
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();

    // R2 R5: 32-level chain through pair 4, exhausted in the last stage
    node_wr(1, 4, 1'b0, 4);
    for (int s = 2; s < ADDR_W; s++) node_wr(s, 8, 1'b0, 4);
    @(negedge clk);
    push(32'h8000_0000, 1'b1, 8'd0, "R5 last level");
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    node_wr(ADDR_W - 1, 8, 1'b1, 8'h55);
    @(negedge clk);
    push(32'h8000_0000, 1'b0, 8'h55, "R2 full-length leaf");
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R7: write to root word 1 in the same cycle as a read of it
    @(negedge clk);
    push(32'hC000_0000, 1'b0, 8'd7, "R7 old data");
    wr_en = 1'b1; wr_stage = '0; wr_index = IDX_W'(1); wr_leaf = 1'b1; wr_payload = 8'd9;
    @(negedge clk);
    wr_en = 1'b0;
    push(32'hC000_0000, 1'b0, 8'd9, "R7 new data");
    @(negedge clk);
    push(32'h2000_0000, 1'b0, 8'd1, "R7 no stall");
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R8: reset drops lookups in flight
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    flushing = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 valid in mid reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    repeat (ADDR_W + 8) @(negedge clk);
    chk("R8 flushed lookups", 32'(flush_seen), 32'd0);
    flushing = 1'b0;

    // memories keep their contents across reset
    push(32'h4800_0000, 1'b0, 8'd4, "R6 after reset");
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk("R6 result count", 32'(rd_q), 32'(wr_q));
    finish_up();
  end

endmodule